// File: doc/BRIEF.md
# Flushable Byte FIFO Pair with Threshold Flags

This block holds two byte queues for a serial bus master. The transmit queue is filled by software through a write strobe and drained by the bus engine through a pop strobe. The receive queue is filled by the bus engine through a push strobe and drained by software through a read strobe. Each queue reports its occupancy and a set of registered level flags that an interrupt controller can use directly as sources.

Each queue has a programmable threshold of up to 15. The transmit side raises a low-water flag when its occupancy is at or below the threshold. The receive side raises a high-water flag when its occupancy is at or above its threshold. A write into a full transmit queue is dropped and sets a sticky overrun flag.

Either queue can be emptied by a flush request. The request bit reads high for a fixed number of cycles and then clears itself. While it is high, every strobe aimed at that queue is ignored. Software is expected to poll the request bit until it reads zero before using the queue again.

Top module: `tfp_fifo_pair`

## Requirements
- R1: After a synchronous reset, both levels are 0, both empty flags are 1, both full flags are 0, the overrun flag is 0, both flush-busy bits are 0, and the TX low-water flag is 1.
- R2: Bytes written through the TX write strobe leave through the bus pop strobe in write order. The byte appears on `bus_tx_data` in the cycle after the pop edge.
- R3: Bytes pushed through the bus push strobe leave through the RX read strobe in push order. The byte appears on `rx_rd_data` in the cycle after the read edge.
- R4: After each clock edge, each level output equals the queue occupancy, from 0 to 16. Empty is 1 exactly at level 0, and full is 1 exactly at level 16.
- R5: `tx_near_empty` is 1 exactly when the TX level is less than or equal to `tx_thr`.
- R6: `rx_near_full` is 1 exactly when the RX level is greater than or equal to `rx_thr`.
- R7: A TX write while `tx_full` is 1 is discarded and sets `tx_ovr` at the next edge. `tx_ovr` stays 1 until `tx_ovr_clr` is pulsed.
- R8: A flush request sets the matching busy bit at the next edge. The bit stays 1 for exactly FLUSH_CYC cycles (default 4) and then clears itself. When it clears, that queue is empty, and the other queue is unchanged.
- R9: While a queue's busy bit is 1, writes, reads, pushes and pops aimed at that queue are ignored, so its level does not change.
- R10: A pop or read of an empty queue, and a bus push into a full RX queue, leave the level unchanged and produce no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr_en | input | 1 | Software write strobe for the TX queue |
| tx_wr_data | input | 8 | Byte to write into the TX queue |
| rx_rd_en | input | 1 | Software read strobe for the RX queue |
| rx_rd_data | output | 8 | Byte read from the RX queue, valid the cycle after the read |
| tx_flush_req | input | 1 | Pulse that starts a TX flush |
| rx_flush_req | input | 1 | Pulse that starts an RX flush |
| tx_flush_busy | output | 1 | TX flush request bit; clears itself when the flush ends |
| rx_flush_busy | output | 1 | RX flush request bit; clears itself when the flush ends |
| tx_thr | input | 4 | TX low-water threshold (0 to 15) |
| rx_thr | input | 4 | RX high-water threshold (0 to 15) |
| tx_ovr_clr | input | 1 | Clears the TX overrun flag |
| bus_tx_pop | input | 1 | Bus engine pop strobe for the TX queue |
| bus_tx_data | output | 8 | Popped TX byte, valid the cycle after the pop |
| bus_rx_push | input | 1 | Bus engine push strobe for the RX queue |
| bus_rx_data | input | 8 | Byte to push into the RX queue |
| tx_level | output | 5 | TX occupancy |
| rx_level | output | 5 | RX occupancy |
| tx_empty | output | 1 | TX level is 0 |
| tx_near_empty | output | 1 | TX level is at or below `tx_thr` |
| tx_full | output | 1 | TX level is 16 |
| tx_ovr | output | 1 | Sticky TX overrun flag |
| rx_empty | output | 1 | RX level is 0 |
| rx_near_full | output | 1 | RX level is at or above `rx_thr` |
| rx_full | output | 1 | RX level is 16 |

## Verification
The assertions assume that reset is synchronous and that each strobe is a single-cycle level sampled at the rising edge. The hold property during a flush also assumes that the busy and done signals come only from the flush sequencer. The overrun stickiness property treats a clear and a fresh overrun in the same cycle as a set.

The stimulus changes thresholds only while no flag is being checked. It drives each strobe for exactly one cycle from the falling edge. It issues a flush request only when no flush is running, so every busy window starts cleanly from idle.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
  typedef enum logic {FL_IDLE = 1'b0, FL_RUN = 1'b1} flush_st_e;
  typedef enum logic {CMP_AT_MOST = 1'b0, CMP_AT_LEAST = 1'b1} thr_cmp_e;
endpackage

// File: rtl/tfp_flush_seq.sv
module tfp_flush_seq
  import tfp_pkg::*;
#(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);

  flush_st_e     st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= FL_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        FL_IDLE: if (req) begin
          st_q  <= FL_RUN;
          cnt_q <= CW'(CYC - 1);
        end
        default: begin
          if (cnt_q == '0) st_q <= FL_IDLE;
          else             cnt_q <= cnt_q - CW'(1);
        end
      endcase
    end
  end

  assign busy = (st_q == FL_RUN);
  assign done = busy && (cnt_q == '0);

  // R8: a request from idle raises busy at the next edge
  assert_flush_start_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && req) |=> busy);
  // R8: busy clears itself after the final cycle
  assert_flush_selfclear_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: rtl/tfp_byte_fifo.sv
module tfp_byte_fifo
  import tfp_pkg::*;
#(
  parameter int       DW    = 8,
  parameter int       DEPTH = 16,
  parameter int       TW    = 4,
  parameter thr_cmp_e CMP   = CMP_AT_MOST
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       busy,
  input  logic                       done,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              pop_data,
  input  logic [TW-1:0]              thr,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       empty,
  output logic                       full,
  output logic                       near
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q, lvl_nx, thr_x;
  logic          empty_q, full_q, near_q, near_nx, near_zero;
  logic          do_push, do_pop;
  logic [DW-1:0] rd_q;

  assign thr_x   = LW'(thr);
  assign do_push = push && !busy && !full_q;
  assign do_pop  = pop && !busy && !empty_q;

  always_comb begin
    lvl_nx = lvl_q;
    if (done) lvl_nx = '0;
    else begin
      case ({do_push, do_pop})
        2'b10:   lvl_nx = lvl_q + LW'(1);
        2'b01:   lvl_nx = lvl_q - LW'(1);
        default: lvl_nx = lvl_q;
      endcase
    end
  end

  generate
    if (CMP == CMP_AT_MOST) begin : g_low_water
      assign near_nx   = (lvl_nx <= thr_x);
      assign near_zero = 1'b1;
    end else begin : g_high_water
      assign near_nx   = (lvl_nx >= thr_x);
      assign near_zero = (thr_x == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (do_pop) rd_q <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q    <= '0;
      rp_q    <= '0;
      lvl_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      near_q  <= near_zero;
    end else begin
      if (done) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (do_push) wp_q <= wp_q + AW'(1);
        if (do_pop)  rp_q <= rp_q + AW'(1);
      end
      lvl_q   <= lvl_nx;
      empty_q <= (lvl_nx == '0);
      full_q  <= (lvl_nx == LW'(DEPTH));
      near_q  <= near_nx;
    end
  end

  assign pop_data = rd_q;
  assign level    = lvl_q;
  assign empty    = empty_q;
  assign full     = full_q;
  assign near     = near_q;

  // R4: occupancy never exceeds the depth
  assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  // R4: empty and full are never both set
  assert_flag_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));
  // R9: strobes during a running flush leave the level alone
  assert_flush_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (level == $past(level)));
  // R8: the queue is empty once the flush completes
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (empty && level == '0));
  // R10: a push into a full queue is dropped
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !busy) |=> (level == $past(level)));
endmodule

// File: rtl/tfp_fifo_pair.sv
module tfp_fifo_pair
  import tfp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int TW        = 4,
  parameter int FLUSH_CYC = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tx_wr_en,
  input  logic [DW-1:0]          tx_wr_data,
  input  logic                   rx_rd_en,
  output logic [DW-1:0]          rx_rd_data,
  input  logic                   tx_flush_req,
  input  logic                   rx_flush_req,
  output logic                   tx_flush_busy,
  output logic                   rx_flush_busy,
  input  logic [TW-1:0]          tx_thr,
  input  logic [TW-1:0]          rx_thr,
  input  logic                   tx_ovr_clr,
  input  logic                   bus_tx_pop,
  output logic [DW-1:0]          bus_tx_data,
  input  logic                   bus_rx_push,
  input  logic [DW-1:0]          bus_rx_data,
  output logic [$clog2(DEPTH):0] tx_level,
  output logic [$clog2(DEPTH):0] rx_level,
  output logic                   tx_empty,
  output logic                   tx_near_empty,
  output logic                   tx_full,
  output logic                   tx_ovr,
  output logic                   rx_empty,
  output logic                   rx_near_full,
  output logic                   rx_full
);
  logic tx_busy, tx_done, rx_busy, rx_done;
  logic ovr_q;

  tfp_flush_seq #(.CYC(FLUSH_CYC)) u_tx_flush (
    .clk(clk), .rst(rst), .req(tx_flush_req), .busy(tx_busy), .done(tx_done));

  tfp_flush_seq #(.CYC(FLUSH_CYC)) u_rx_flush (
    .clk(clk), .rst(rst), .req(rx_flush_req), .busy(rx_busy), .done(rx_done));

  tfp_byte_fifo #(.DW(DW), .DEPTH(DEPTH), .TW(TW), .CMP(CMP_AT_MOST)) u_tx_q (
    .clk(clk), .rst(rst), .busy(tx_busy), .done(tx_done),
    .push(tx_wr_en), .push_data(tx_wr_data),
    .pop(bus_tx_pop), .pop_data(bus_tx_data),
    .thr(tx_thr), .level(tx_level), .empty(tx_empty),
    .full(tx_full), .near(tx_near_empty));

  tfp_byte_fifo #(.DW(DW), .DEPTH(DEPTH), .TW(TW), .CMP(CMP_AT_LEAST)) u_rx_q (
    .clk(clk), .rst(rst), .busy(rx_busy), .done(rx_done),
    .push(bus_rx_push), .push_data(bus_rx_data),
    .pop(rx_rd_en), .pop_data(rx_rd_data),
    .thr(rx_thr), .level(rx_level), .empty(rx_empty),
    .full(rx_full), .near(rx_near_full));

  always_ff @(posedge clk) begin
    if (rst)                                   ovr_q <= 1'b0;
    else if (tx_wr_en && !tx_busy && tx_full)  ovr_q <= 1'b1;
    else if (tx_ovr_clr)                       ovr_q <= 1'b0;
  end

  assign tx_ovr        = ovr_q;
  assign tx_flush_busy = tx_busy;
  assign rx_flush_busy = rx_busy;

  // R7: overrun is sticky until cleared
  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_ovr && !tx_ovr_clr) |=> tx_ovr);
  // R7: a write into a full queue raises overrun
  assert_ovr_set_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_wr_en && tx_full && !tx_flush_busy) |=> tx_ovr);
endmodule

// File: tb/tb_tfp_fifo_pair.sv
`timescale 1ns/1ps
module tb_tfp_fifo_pair;
  localparam int DEPTH = 16;
  localparam int FLC   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_wr_en = 0, rx_rd_en = 0, tx_flush_req = 0, rx_flush_req = 0;
  logic tx_ovr_clr = 0, bus_tx_pop = 0, bus_rx_push = 0;
  logic [7:0] tx_wr_data = 0, bus_rx_data = 0, rx_rd_data, bus_tx_data;
  logic [3:0] tx_thr = 4'd3, rx_thr = 4'd5;
  logic tx_flush_busy, rx_flush_busy;
  logic [4:0] tx_level, rx_level;
  logic tx_empty, tx_near_empty, tx_full, tx_ovr, rx_empty, rx_near_full, rx_full;

  int checks = 0, fails = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  bit tx_hold = 0, rx_hold = 0, tx_chk = 0, rx_chk = 0;

  always #10 clk = ~clk;

  tfp_fifo_pair dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: mark edges where a real pop/read happened, compare a cycle later
  always @(posedge clk) begin
    tx_chk <= bus_tx_pop && !tx_hold && (tx_q.size() != 0);
    rx_chk <= rx_rd_en && !rx_hold && (rx_q.size() != 0);
  end
  always @(negedge clk) begin
    if (tx_chk) begin
      logic [7:0] e;
      e = tx_q.pop_front();
      check(bus_tx_data == e, "R2 tx order", bus_tx_data, e);
    end
    if (rx_chk) begin
      logic [7:0] e;
      e = rx_q.pop_front();
      check(rx_rd_data == e, "R3 rx order", rx_rd_data, e);
    end
  end

  task automatic tx_write(input logic [7:0] d);
    tx_wr_en = 1; tx_wr_data = d;
    if (tx_q.size() < DEPTH && !tx_hold) tx_q.push_back(d);
    @(negedge clk); tx_wr_en = 0; #1;
  endtask
  task automatic tx_pop();
    bus_tx_pop = 1; @(negedge clk); bus_tx_pop = 0; #1;
  endtask
  task automatic rx_push(input logic [7:0] d);
    bus_rx_push = 1; bus_rx_data = d;
    if (rx_q.size() < DEPTH && !rx_hold) rx_q.push_back(d);
    @(negedge clk); bus_rx_push = 0; #1;
  endtask
  task automatic rx_read();
    rx_rd_en = 1; @(negedge clk); rx_rd_en = 0; #1;
  endtask

  task automatic chk_tx(input string tag);
    int n;
    n = tx_q.size();
    check(tx_level == n, {tag, " R4 tx level"}, tx_level, n);
    check(tx_empty == (n == 0), {tag, " R4 tx empty"}, tx_empty, n == 0);
    check(tx_full == (n == DEPTH), {tag, " R4 tx full"}, tx_full, n == DEPTH);
    check(tx_near_empty == (n <= tx_thr), {tag, " R5 tx near-empty"}, tx_near_empty, n <= tx_thr);
  endtask
  task automatic chk_rx(input string tag);
    int n;
    n = rx_q.size();
    check(rx_level == n, {tag, " R4 rx level"}, rx_level, n);
    check(rx_empty == (n == 0), {tag, " R4 rx empty"}, rx_empty, n == 0);
    check(rx_full == (n == DEPTH), {tag, " R4 rx full"}, rx_full, n == DEPTH);
    check(rx_near_full == (n >= rx_thr), {tag, " R6 rx near-full"}, rx_near_full, n >= rx_thr);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    rst = 0; #1;
    // R1 reset state
    check(tx_level == 0 && rx_level == 0, "R1 levels", {tx_level, rx_level}, 0);
    check(tx_empty && rx_empty && !tx_full && !rx_full, "R1 empty/full",
          {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    check(!tx_ovr && !tx_flush_busy && !rx_flush_busy, "R1 ovr/busy",
          {tx_ovr, tx_flush_busy, rx_flush_busy}, 0);
    check(tx_near_empty == 1, "R1 tx near-empty", tx_near_empty, 1);
    chk_rx("R1");

    // R2 / R5: order and low-water threshold 3
    for (int i = 0; i < 5; i++) tx_write(8'h10 + 8'(i));
    chk_tx("five");
    tx_pop(); tx_pop();
    chk_tx("three");
    tx_pop(); tx_pop(); tx_pop();
    chk_tx("drained");
    // R10: pop on empty
    tx_pop();
    check(tx_level == 0 && tx_empty, "R10 pop empty", tx_level, 0);

    // R4 / R5 / R7: fill to full with threshold 15, then overrun
    tx_thr = 4'd15;
    @(negedge clk); #1;
    for (int i = 0; i < DEPTH; i++) tx_write(8'hA0 + 8'(i));
    chk_tx("full");
    check(!tx_ovr, "R7 no ovr yet", tx_ovr, 0);
    tx_write(8'hEE);
    check(tx_ovr == 1, "R7 ovr set", tx_ovr, 1);
    check(tx_level == DEPTH, "R7 byte dropped", tx_level, DEPTH);
    repeat (3) @(negedge clk); #1;
    check(tx_ovr == 1, "R7 ovr sticky", tx_ovr, 1);
    tx_pop();
    chk_tx("fifteen");
    while (tx_q.size() != 0) tx_pop();
    check(tx_ovr == 1, "R7 ovr after drain", tx_ovr, 1);
    tx_ovr_clr = 1; @(negedge clk); tx_ovr_clr = 0; #1;
    check(tx_ovr == 0, "R7 ovr cleared", tx_ovr, 0);
    tx_thr = 4'd3;
    @(negedge clk); #1;

    // R3 / R6: RX order and high-water threshold 5
    for (int i = 0; i < 4; i++) rx_push(8'h50 + 8'(i));
    chk_rx("four");
    rx_push(8'h54);
    chk_rx("five");
    rx_read(); rx_read();
    chk_rx("three");
    for (int i = 0; i < 13; i++) rx_push(8'h60 + 8'(i));
    chk_rx("rx full");
    rx_push(8'hFF);
    check(rx_level == DEPTH, "R10 push full", rx_level, DEPTH);
    while (rx_q.size() != 0) rx_read();
    chk_rx("rx drained");
    rx_read();
    check(rx_level == 0 && rx_empty, "R10 read empty", rx_level, 0);

    // R8 / R9: TX flush
    for (int i = 0; i < 6; i++) tx_write(8'hC0 + 8'(i));
    for (int i = 0; i < 3; i++) rx_push(8'hD0 + 8'(i));
    tx_flush_req = 1; @(negedge clk); tx_flush_req = 0; #1;
    check(tx_flush_busy == 1, "R8 tx busy set", tx_flush_busy, 1);
    n = 1;
    tx_hold = 1;
    tx_wr_en = 1; tx_wr_data = 8'h77; bus_tx_pop = 1;
    @(negedge clk); tx_wr_en = 0; bus_tx_pop = 0; #1;
    check(tx_level == 6, "R9 tx strobes ignored", tx_level, 6);
    for (int i = 0; i < 5; i++) begin
      if (tx_flush_busy) n++;
      @(negedge clk); #1;
    end
    check(n == FLC, "R8 tx busy length", n, FLC);
    check(tx_flush_busy == 0, "R8 tx self clear", tx_flush_busy, 0);
    tx_q.delete();
    tx_hold = 0;
    chk_tx("R8 after flush");
    chk_rx("R8 rx untouched");
    tx_write(8'h31); tx_write(8'h32);
    tx_pop(); tx_pop();
    chk_tx("R8 reuse");

    // R8 / R9: RX flush
    rx_flush_req = 1; @(negedge clk); rx_flush_req = 0; #1;
    check(rx_flush_busy == 1, "R8 rx busy set", rx_flush_busy, 1);
    rx_hold = 1;
    bus_rx_push = 1; bus_rx_data = 8'h99; rx_rd_en = 1;
    @(negedge clk); bus_rx_push = 0; rx_rd_en = 0; #1;
    check(rx_level == 3, "R9 rx strobes ignored", rx_level, 3);
    repeat (4) @(negedge clk); #1;
    check(rx_flush_busy == 0, "R8 rx self clear", rx_flush_busy, 0);
    rx_q.delete();
    rx_hold = 0;
    chk_rx("R8 rx after flush");
    rx_push(8'h42); rx_read();
    chk_rx("R8 rx reuse");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule